// File: doc/BRIEF.md
# Memory Clock Stop Controller

This controller sits between a memory command scheduler and the command pins of a double-data-rate memory. It decides when the memory clock can be halted while the memory has no work, and it restarts the clock cleanly when work comes back. Access commands (activate, read, write, precharge, refresh, mode-register load) reach it over a valid/ready request port. It places each accepted command on the memory command bus for one cycle and then drives NOP.

For every accepted access command the controller loads a hold counter with the number of cycles that command still needs after its own cycle. For a read, that is the latency plus the data-out beats. For any other command, it is that command's own recovery time. The controller asserts `clk_stop` only when three things are true: the counter has reached zero, clock enable is high, and no request is waiting. `clk_stop` tells the clock generator to freeze the pair with the true clock low and the complement clock high.

A waiting request, or clock enable going low, releases the clock. The controller then sends a fixed number of NOP cycles before it accepts the next request.

Top module: `cgc_clock_stop`

## Requirements
- R1: During and right after reset, `clk_stop` is 0, `mem_cmd` is NOP (code 0) and `req_ready` is 1.
- R2: A request taken when `req_valid` and `req_ready` are both high, with an access code, appears on `mem_cmd` in the next cycle for exactly one cycle. `mem_cmd` returns to NOP afterwards unless another access is taken.
- R3: `req_ready` is 0 whenever `clk_stop` is 1 and during the restart NOP cycles. Back-pressure holds the request: `req_valid` and `req_cmd` must stay unchanged until taken.
- R4: With clock enable high and no request, `clk_stop` rises exactly L+1 cycles after the command cycle on `mem_cmd`. L for each command is:
  - activate: T_RCD
  - read: CAS_LAT + BURST_LEN/2
  - write: 1 + BURST_LEN/2 + T_WR
  - precharge: T_RP
  - refresh: T_RFC
  - mode-register load: T_MRD
- R5: `clk_stop` never rises while `cke` is 0, and `cke` going low while stopped releases the clock on the next cycle.
- R6: A pending request blocks the stop even when the hold counter has expired. A request taken during a countdown is issued with the clock running.
- R7: A request arriving while stopped lowers `clk_stop` in the next cycle. Then `req_ready` stays 0 for RESTART_NOPS cycles and rises in the cycle after, with `mem_cmd` at NOP throughout.
- R8: The command codes are: NOP 0, activate 1, read 2, write 3, precharge 4, refresh 5, mode-register load 6, reserved 7. A taken request coded 0 or 7 leaves `mem_cmd` at NOP and does not change the hold counter.
- R9: Once high, `clk_stop` stays high for as long as `cke` is 1 and `req_valid` is 0.
- R10: `mem_cmd` is NOP in every cycle that `clk_stop` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable level driven to the memory |
| req_valid | input | 1 | Command request valid |
| req_cmd | input | 3 | Requested command code |
| req_ready | output | 1 | Request accepted when high together with valid |
| mem_cmd | output | 3 | Command presented to the memory |
| clk_stop | output | 1 | Freeze memory clock (true low, complement high) |

## Verification
The bench measures the exact stop cycle for each of the six commands. A design that miscounts read data-out, or that uses the wrong recovery time for a command, stops the clock one or more cycles early or late.

It also aims a request at the very cycle the counter expires. A design that ignores pending requests halts the clock with work queued.

Other scenarios cover:
- clock enable dropping, both while stopped and while idle;
- the restart sequence, where a design that skips the NOP would issue a command on the first restarted edge;
- reserved codes arriving mid-countdown, which a careless design would treat as a reload that stretches the hold.

// File: rtl/cgc_pkg.sv
package cgc_pkg;

  localparam int CMD_W = 3;

  localparam logic [CMD_W-1:0] CMD_NOP = 3'd0;
  localparam logic [CMD_W-1:0] CMD_ACT = 3'd1;
  localparam logic [CMD_W-1:0] CMD_RD  = 3'd2;
  localparam logic [CMD_W-1:0] CMD_WR  = 3'd3;
  localparam logic [CMD_W-1:0] CMD_PRE = 3'd4;
  localparam logic [CMD_W-1:0] CMD_REF = 3'd5;
  localparam logic [CMD_W-1:0] CMD_MRS = 3'd6;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_HALT = 2'd1,
    ST_WAKE = 2'd2
  } cgc_state_e;

  function automatic logic is_access(input logic [CMD_W-1:0] c);
    return (c >= CMD_ACT) && (c <= CMD_MRS);
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Cycles a command still needs after its own command cycle.
  function automatic int hold_len(input logic [CMD_W-1:0] c,
                                  input int cl, input int bl,
                                  input int trcd, input int twr,
                                  input int trp, input int trfc,
                                  input int tmrd);
    int r;
    case (c)
      CMD_ACT: r = trcd;
      CMD_RD:  r = cl + bl / 2;
      CMD_WR:  r = 1 + bl / 2 + twr;
      CMD_PRE: r = trp;
      CMD_REF: r = trfc;
      CMD_MRS: r = tmrd;
      default: r = 0;
    endcase
    return r;
  endfunction

  function automatic int hold_max(input int cl, input int bl,
                                  input int trcd, input int twr,
                                  input int trp, input int trfc,
                                  input int tmrd);
    int m;
    m = imax(trcd, cl + bl / 2);
    m = imax(m, 1 + bl / 2 + twr);
    m = imax(m, trp);
    m = imax(m, trfc);
    m = imax(m, tmrd);
    return m;
  endfunction

endpackage

// File: rtl/cgc_hold_timer.sv
module cgc_hold_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/cgc_wake_pacer.sv
module cgc_wake_pacer #(
  parameter int NOPS = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic last
);

  localparam int PW = $clog2(NOPS + 1);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= PW'(NOPS);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign last = (cnt_q == PW'(1));

endmodule

// File: rtl/cgc_clock_stop.sv
module cgc_clock_stop #(
  parameter int CAS_LAT      = 3,
  parameter int BURST_LEN    = 4,
  parameter int T_RCD        = 3,
  parameter int T_WR         = 3,
  parameter int T_RP         = 4,
  parameter int T_RFC        = 12,
  parameter int T_MRD        = 2,
  parameter int RESTART_NOPS = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cke,
  input  logic       req_valid,
  input  logic [2:0] req_cmd,
  output logic       req_ready,
  output logic [2:0] mem_cmd,
  output logic       clk_stop
);
  import cgc_pkg::*;

  localparam int HOLD_MAX = hold_max(CAS_LAT, BURST_LEN, T_RCD, T_WR,
                                     T_RP, T_RFC, T_MRD);
  localparam int TW = $clog2(HOLD_MAX + 1);

  cgc_state_e state_q, state_d;
  logic [CMD_W-1:0] mem_cmd_q;
  logic take, take_access, hold_done, stop_now, wake_now, wake_last;
  logic [TW-1:0] hold_val;

  assign req_ready   = (state_q == ST_RUN);
  assign take        = req_valid && req_ready;
  assign take_access = take && is_access(req_cmd);
  assign hold_val    = TW'(hold_len(req_cmd, CAS_LAT, BURST_LEN, T_RCD,
                                    T_WR, T_RP, T_RFC, T_MRD));
  assign stop_now    = (state_q == ST_RUN) && hold_done && cke && !req_valid;
  assign wake_now    = (state_q == ST_HALT) && (req_valid || !cke);

  cgc_hold_timer #(.W(TW)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (take_access),
    .load_val (hold_val),
    .expired  (hold_done)
  );

  cgc_wake_pacer #(.NOPS(RESTART_NOPS)) u_pace (
    .clk   (clk),
    .rst_n (rst_n),
    .start (wake_now),
    .last  (wake_last)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_RUN:  if (stop_now)  state_d = ST_HALT;
      ST_HALT: if (wake_now)  state_d = ST_WAKE;
      ST_WAKE: if (wake_last) state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_RUN;
      mem_cmd_q <= CMD_NOP;
    end else begin
      state_q   <= state_d;
      mem_cmd_q <= take_access ? req_cmd : CMD_NOP;
    end
  end

  assign mem_cmd  = mem_cmd_q;
  assign clk_stop = (state_q == ST_HALT);

endmodule

// File: rtl/cgc_clock_stop_chk.sv
module cgc_clock_stop_chk #(
  parameter int CAS_LAT      = 3,
  parameter int BURST_LEN    = 4,
  parameter int T_RCD        = 3,
  parameter int T_WR         = 3,
  parameter int T_RP         = 4,
  parameter int T_RFC        = 12,
  parameter int T_MRD        = 2,
  parameter int RESTART_NOPS = 1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cke,
  input logic       req_valid,
  input logic [2:0] req_cmd,
  input logic       req_ready,
  input logic [2:0] mem_cmd,
  input logic       clk_stop
);
  import cgc_pkg::*;

  localparam int HOLD_MAX = hold_max(CAS_LAT, BURST_LEN, T_RCD, T_WR,
                                     T_RP, T_RFC, T_MRD);
  localparam int TW = $clog2(HOLD_MAX + 1);

  logic [TW-1:0] rem_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q <= '0;
    end else if (req_valid && req_ready && is_access(req_cmd)) begin
      rem_q <= TW'(hold_len(req_cmd, CAS_LAT, BURST_LEN, T_RCD, T_WR,
                            T_RP, T_RFC, T_MRD));
    end else if (rem_q != '0) begin
      rem_q <= rem_q - 1'b1;
    end
  end

  p_issue_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && is_access(req_cmd)) |=> (mem_cmd == $past(req_cmd)));

  p_no_ready_stopped_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clk_stop |-> !req_ready);

  p_hold_elapsed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clk_stop |-> (rem_q == '0));

  p_cke_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_stop && !cke) |=> !clk_stop);

  p_no_stop_cke_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_stop && !cke) |=> !clk_stop);

  p_pending_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_stop && req_valid) |=> !clk_stop);

  p_restart_on_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_stop && req_valid) |=> (!clk_stop && !req_ready));

  p_stop_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_stop && cke && !req_valid) |=> clk_stop);

  p_nop_stopped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clk_stop |-> (mem_cmd == CMD_NOP));

endmodule

bind cgc_clock_stop cgc_clock_stop_chk #(
  .CAS_LAT(CAS_LAT), .BURST_LEN(BURST_LEN), .T_RCD(T_RCD), .T_WR(T_WR),
  .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD), .RESTART_NOPS(RESTART_NOPS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cke(cke), .req_valid(req_valid),
  .req_cmd(req_cmd), .req_ready(req_ready), .mem_cmd(mem_cmd),
  .clk_stop(clk_stop)
);

// File: tb/tb_cgc_clock_stop.sv
`timescale 1ns/1ps
module tb_cgc_clock_stop;

  localparam int CL = 3, BL = 4, TRCD = 3, TWR = 3, TRP = 4, TRFC = 12, TMRD = 2;
  localparam int NOPS = 1;

  logic clk = 1'b0;
  logic rst_n, cke, req_valid, req_ready, clk_stop;
  logic [2:0] req_cmd, mem_cmd;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  cgc_clock_stop #(
    .CAS_LAT(CL), .BURST_LEN(BL), .T_RCD(TRCD), .T_WR(TWR),
    .T_RP(TRP), .T_RFC(TRFC), .T_MRD(TMRD), .RESTART_NOPS(NOPS)
  ) dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .req_valid(req_valid),
    .req_cmd(req_cmd), .req_ready(req_ready), .mem_cmd(mem_cmd),
    .clk_stop(clk_stop)
  );

  // Hold length per command, from requirement R4.
  function automatic int exp_len(input int c);
    case (c)
      1: return TRCD;
      2: return CL + BL / 2;
      3: return 1 + BL / 2 + TWR;
      4: return TRP;
      5: return TRFC;
      6: return TMRD;
      default: return 0;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // Wake from stop with a request and get it taken (R7, R3, R2).
  task automatic wake_issue(input logic [2:0] c);
    req_valid = 1'b1;
    req_cmd   = c;
    step();
    check(clk_stop == 1'b0, "R7 clk_stop falls", clk_stop, 0);
    for (int i = 0; i < NOPS; i++) begin
      if (i > 0) step();
      check(req_ready == 1'b0, "R3 ready low in restart", req_ready, 0);
      check(mem_cmd == 3'd0, "R7 NOP in restart", mem_cmd, 0);
    end
    step();
    check(req_ready == 1'b1, "R7 ready after NOPs", req_ready, 1);
    check(mem_cmd == 3'd0, "R7 NOP before command", mem_cmd, 0);
    step();
    req_valid = 1'b0;
  endtask

  // After the command cycle, expect L running cycles then the stop (R4, R2, R10).
  task automatic expect_stop(input int len);
    for (int i = 0; i < len; i++) begin
      step();
      check(clk_stop == 1'b0, "R4 no early stop", clk_stop, 0);
      check(mem_cmd == 3'd0, "R2 single command cycle", mem_cmd, 0);
    end
    step();
    check(clk_stop == 1'b1, "R4 stop at L+1", clk_stop, 1);
    check(mem_cmd == 3'd0, "R10 NOP while stopped", mem_cmd, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cke = 1'b1; req_valid = 1'b0; req_cmd = 3'd0;
    repeat (3) step();
    check(clk_stop == 1'b0, "R1 clk_stop in reset", clk_stop, 0);
    check(mem_cmd == 3'd0, "R1 mem_cmd in reset", mem_cmd, 0);
    check(req_ready == 1'b1, "R1 ready in reset", req_ready, 1);
    rst_n = 1'b1;
    check(clk_stop == 1'b0, "R1 clk_stop after reset", clk_stop, 0);
    step();
    check(clk_stop == 1'b1, "R4 idle stop after reset", clk_stop, 1);
    repeat (5) begin
      step();
      check(clk_stop == 1'b1, "R9 stop holds", clk_stop, 1);
      check(req_ready == 1'b0, "R3 ready low while stopped", req_ready, 0);
    end
  endtask

  task automatic t_each_command();
    for (int c = 1; c <= 6; c++) begin
      wake_issue(3'(c));
      check(mem_cmd == 3'(c), "R2 command on bus", mem_cmd, c);
      expect_stop(exp_len(c));
    end
  endtask

  task automatic t_pending_blocks();
    wake_issue(3'd1);
    check(mem_cmd == 3'd1, "R2 ACT on bus", mem_cmd, 1);
    repeat (TRCD) begin
      step();
      check(clk_stop == 1'b0, "R6 counting", clk_stop, 0);
    end
    req_valid = 1'b1; req_cmd = 3'd4;
    step();
    req_valid = 1'b0;
    check(clk_stop == 1'b0, "R6 pending request blocks stop", clk_stop, 0);
    check(mem_cmd == 3'd4, "R6 issued without gating", mem_cmd, 4);
    expect_stop(exp_len(4));
    // request mid-countdown of a read: clock never stops in between
    wake_issue(3'd2);
    step();
    req_valid = 1'b1; req_cmd = 3'd1;
    step();
    req_valid = 1'b0;
    check(clk_stop == 1'b0, "R6 mid-count issue", clk_stop, 0);
    check(mem_cmd == 3'd1, "R6 second command", mem_cmd, 1);
    expect_stop(exp_len(1));
  endtask

  task automatic t_cke();
    cke = 1'b0;
    step();
    check(clk_stop == 1'b0, "R5 cke low releases", clk_stop, 0);
    repeat (6) begin
      step();
      check(clk_stop == 1'b0, "R5 no stop with cke low", clk_stop, 0);
    end
    check(req_ready == 1'b1, "R5 running ready", req_ready, 1);
    cke = 1'b1;
    step();
    check(clk_stop == 1'b1, "R5 stop after cke high", clk_stop, 1);
  endtask

  task automatic t_reserved();
    wake_issue(3'd7);
    check(mem_cmd == 3'd0, "R8 reserved stays NOP", mem_cmd, 0);
    step();
    check(clk_stop == 1'b1, "R8 reserved no hold", clk_stop, 1);
    wake_issue(3'd1);
    req_valid = 1'b1; req_cmd = 3'd0;
    step();
    req_valid = 1'b0;
    check(mem_cmd == 3'd0, "R8 NOP code stays NOP", mem_cmd, 0);
    // ACT took one cycle already; counter not reloaded
    expect_stop(exp_len(1) - 1);
  endtask

  initial begin
    t_reset();
    t_each_command();
    t_pending_blocks();
    t_cke();
    t_reserved();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule